// File: doc/BRIEF.md
# DMA channel control register file

This block holds the control and status state of a multi-channel DMA engine and serves it over a simple device-control register bus. A bus master gives a 10-bit register number with a read or a write strobe. One cycle later the block raises a one-cycle acknowledge, and for a read it presents the registered read data. Each writable register keeps only the bits its mask allows. The five status registers clear the bits that are 1 in the write data. The per-channel active-set registers, active-reset registers, descriptor table pointers and receive buffer sizes are plain storage.

Setting the top bit of a configuration write starts a partial soft reset. The reset clears the control and status registers, and the masked write value then lands in the configuration register in the same cycle. The table pointers, the buffer sizes and the active-reset registers keep their contents through this reset and through power-on reset. Status bits come from a side input for each status register. That input is ORed into the stored value and takes priority over a clear in the same cycle. The block does not decide when to interrupt: its four interrupt lines are registered and held low.

Top module: `dma_ctl_regfile`

## Requirements
- R1: Each register answers at one fixed register number. Configuration 0x180, error status 0x181, interrupt enable 0x182. Transmit: active-set 0x184, active-reset 0x185, end-of-buffer status 0x186, descriptor error 0x187. Receive: active-set 0x190, active-reset 0x191, end-of-buffer status 0x192, descriptor error 0x193. Transmit table pointers 0x1A0 upward, one per transmit channel. Receive table pointers 0x1C0 upward and receive buffer sizes 0x1E0 upward, one each per receive channel.
- R2: A configuration write stores the write data ANDed with 0x00FFC087, so bit 31 of the configuration register never reads as 1.
- R3: A configuration write with bit 31 set clears error status, interrupt enable, both active-set registers and all four end-of-buffer and descriptor-error registers. In the same cycle it loads configuration with the masked write value.
- R4: After power-on reset, configuration reads 0x0007C000, and error status, interrupt enable, both active-set registers and the four end-of-buffer and descriptor-error registers read 0.
- R5: Neither power-on reset nor soft reset changes the active-reset registers, the table pointers or the buffer sizes.
- R6: A write to error status or to any end-of-buffer or descriptor-error register clears every stored bit whose write-data bit is 1 and leaves the other bits unchanged.
- R7: In every cycle, each bit that is 1 on a status register's set input is set in that register. This holds even when a clear or a soft reset targets the same bit in the same cycle.
- R8: Interrupt enable keeps write bits [4:0]. The transmit active-set and active-reset registers keep the top bits, one per transmit channel (mask 0xF0000000 for 4 channels). The receive pair keeps the top bits, one per receive channel (mask 0xC0000000 for 2 channels).
- R9: Table pointers store all 32 write bits. Buffer sizes store write bits [7:0].
- R10: A read of a register number outside the map returns 0. A write to such a number changes no register.
- R11: Acknowledge is high exactly in the cycle after a read or write strobe. Read data in that cycle holds the register's value from before any write in the strobe cycle.
- R12: All four interrupt outputs stay low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| regNum | input | 10 | Register number of the access |
| wrData | input | 32 | Write data |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| rdData | output | 32 | Registered read data, valid with ack |
| ack | output | 1 | One-cycle acknowledge, the cycle after a strobe |
| errSet | input | 32 | Set bits for error status |
| txEobSet | input | 32 | Set bits for transmit end-of-buffer status |
| txDescErrSet | input | 32 | Set bits for transmit descriptor error |
| rxEobSet | input | 32 | Set bits for receive end-of-buffer status |
| rxDescErrSet | input | 32 | Set bits for receive descriptor error |
| irqOut | output | 4 | Interrupt request lines, held low |

## Verification
The bench builds the block with its defaults: four transmit channels and two receive channels. With those values the active masks are 0xF0000000 and 0xC0000000, and the first unmapped numbers after each table (0x1A4, 0x1C2, 0x1E2) sit right after the last real channel slot, so both the top and the bottom of every range can be probed. Random traffic over all mapped and several unmapped numbers, with set pulses and configuration writes that sometimes carry bit 31, places soft resets, clears and sets in the same cycle. Directed cases cover the wide masks, set-over-clear priority and state kept across both kinds of reset.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  localparam int REGNUM_W = 10;
  localparam int CHIDX_W  = 5;

  localparam logic [REGNUM_W-1:0] REG_CFG     = 10'h180;
  localparam logic [REGNUM_W-1:0] REG_ERR     = 10'h181;
  localparam logic [REGNUM_W-1:0] REG_IEN     = 10'h182;
  localparam logic [REGNUM_W-1:0] REG_TXSET   = 10'h184;
  localparam logic [REGNUM_W-1:0] REG_TXRST   = 10'h185;
  localparam logic [REGNUM_W-1:0] REG_TXEOB   = 10'h186;
  localparam logic [REGNUM_W-1:0] REG_TXDE    = 10'h187;
  localparam logic [REGNUM_W-1:0] REG_RXSET   = 10'h190;
  localparam logic [REGNUM_W-1:0] REG_RXRST   = 10'h191;
  localparam logic [REGNUM_W-1:0] REG_RXEOB   = 10'h192;
  localparam logic [REGNUM_W-1:0] REG_RXDE    = 10'h193;
  localparam logic [REGNUM_W-1:0] REG_TXPTR0  = 10'h1A0;
  localparam logic [REGNUM_W-1:0] REG_RXPTR0  = 10'h1C0;
  localparam logic [REGNUM_W-1:0] REG_BUFSZ0  = 10'h1E0;

  localparam logic [31:0] CFG_KEEP = 32'h00FFC087;
  localparam logic [31:0] CFG_INIT = 32'h0007C000;
  localparam logic [31:0] IEN_KEEP = 32'h0000001F;
  localparam logic [31:0] BUF_KEEP = 32'h000000FF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_ERR, SEL_IEN,
    SEL_TXSET, SEL_TXRST, SEL_TXEOB, SEL_TXDE,
    SEL_RXSET, SEL_RXRST, SEL_RXEOB, SEL_RXDE,
    SEL_TXPTR, SEL_RXPTR, SEL_BUFSZ
  } regSel_e;

  typedef struct packed {
    logic cfgWr;
    logic softRst;
    logic errClr;
    logic ienWr;
    logic txSetWr;
    logic txRstWr;
    logic txEobClr;
    logic txDeClr;
    logic rxSetWr;
    logic rxRstWr;
    logic rxEobClr;
    logic rxDeClr;
    logic txPtrWr;
    logic rxPtrWr;
    logic bufSzWr;
  } wrStrobes_t;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REGNUM_W-1:0] regNum,
  input  logic                rdStb,
  input  logic                wrStb,
  input  logic                wrTopBit,
  output regSel_e             sel,
  output logic [CHIDX_W-1:0]  chanIdx,
  output wrStrobes_t          strb,
  output logic                ack
);

  localparam logic [REGNUM_W-1:0] TXPTR_END = REG_TXPTR0 + REGNUM_W'(TX_CH);
  localparam logic [REGNUM_W-1:0] RXPTR_END = REG_RXPTR0 + REGNUM_W'(RX_CH);
  localparam logic [REGNUM_W-1:0] BUFSZ_END = REG_BUFSZ0 + REGNUM_W'(RX_CH);

  always_comb begin
    sel = SEL_NONE;
    unique case (regNum)
      REG_CFG:   sel = SEL_CFG;
      REG_ERR:   sel = SEL_ERR;
      REG_IEN:   sel = SEL_IEN;
      REG_TXSET: sel = SEL_TXSET;
      REG_TXRST: sel = SEL_TXRST;
      REG_TXEOB: sel = SEL_TXEOB;
      REG_TXDE:  sel = SEL_TXDE;
      REG_RXSET: sel = SEL_RXSET;
      REG_RXRST: sel = SEL_RXRST;
      REG_RXEOB: sel = SEL_RXEOB;
      REG_RXDE:  sel = SEL_RXDE;
      default: begin
        if (regNum >= REG_TXPTR0 && regNum < TXPTR_END)      sel = SEL_TXPTR;
        else if (regNum >= REG_RXPTR0 && regNum < RXPTR_END) sel = SEL_RXPTR;
        else if (regNum >= REG_BUFSZ0 && regNum < BUFSZ_END) sel = SEL_BUFSZ;
        else                                                 sel = SEL_NONE;
      end
    endcase
  end

  // Table bases sit on 32-entry boundaries, so the low bits are the channel.
  assign chanIdx = regNum[CHIDX_W-1:0];

  always_comb begin
    strb          = '0;
    strb.cfgWr    = wrStb && sel == SEL_CFG;
    strb.softRst  = wrStb && sel == SEL_CFG && wrTopBit;
    strb.errClr   = wrStb && sel == SEL_ERR;
    strb.ienWr    = wrStb && sel == SEL_IEN;
    strb.txSetWr  = wrStb && sel == SEL_TXSET;
    strb.txRstWr  = wrStb && sel == SEL_TXRST;
    strb.txEobClr = wrStb && sel == SEL_TXEOB;
    strb.txDeClr  = wrStb && sel == SEL_TXDE;
    strb.rxSetWr  = wrStb && sel == SEL_RXSET;
    strb.rxRstWr  = wrStb && sel == SEL_RXRST;
    strb.rxEobClr = wrStb && sel == SEL_RXEOB;
    strb.rxDeClr  = wrStb && sel == SEL_RXDE;
    strb.txPtrWr  = wrStb && sel == SEL_TXPTR;
    strb.rxPtrWr  = wrStb && sel == SEL_RXPTR;
    strb.bufSzWr  = wrStb && sel == SEL_BUFSZ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ack <= 1'b0;
    else       ack <= rdStb || wrStb;
  end

  assert_ack_after_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb || wrStb) |=> ack);
  assert_ack_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb || wrStb) |=> !ack);

endmodule

// File: rtl/dma_ctl_store.sv
module dma_ctl_store
  import dma_ctl_pkg::*;
#(
  parameter int TX_CH     = 4,
  parameter int RX_CH     = 2,
  parameter int IRQ_LINES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobes_t         strb,
  input  regSel_e            sel,
  input  logic [CHIDX_W-1:0] chanIdx,
  input  logic               rdStb,
  input  logic [31:0]        wrData,
  input  logic [31:0]        errSet,
  input  logic [31:0]        txEobSet,
  input  logic [31:0]        txDescErrSet,
  input  logic [31:0]        rxEobSet,
  input  logic [31:0]        rxDescErrSet,
  output logic [31:0]        rdData,
  output logic [IRQ_LINES-1:0] irqOut
);

  localparam logic [31:0] TX_ACT_KEEP = ~(32'hFFFFFFFF >> TX_CH);
  localparam logic [31:0] RX_ACT_KEEP = ~(32'hFFFFFFFF >> RX_CH);

  logic [31:0] cfgReg, errReg, ienReg;
  logic [31:0] txSetReg, txRstReg, txEobReg, txDeReg;
  logic [31:0] rxSetReg, rxRstReg, rxEobReg, rxDeReg;
  logic [31:0] txPtr [TX_CH];
  logic [31:0] rxPtr [RX_CH];
  logic [31:0] bufSz [RX_CH];
  logic [IRQ_LINES-1:0] irqReg;
  logic [31:0] rdMux;

  // Status update: soft reset or clear first, then the set input wins.
  function automatic logic [31:0] nextStatus(input logic [31:0] cur, input logic clr,
                                             input logic srst, input logic [31:0] wd,
                                             input logic [31:0] setBits);
    logic [31:0] base;
    base = srst ? 32'h0 : (clr ? (cur & ~wd) : cur);
    return base | setBits;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= CFG_INIT;
      errReg   <= '0;
      ienReg   <= '0;
      txSetReg <= '0;
      txEobReg <= '0;
      txDeReg  <= '0;
      rxSetReg <= '0;
      rxEobReg <= '0;
      rxDeReg  <= '0;
    end else begin
      if (strb.cfgWr) cfgReg <= wrData & CFG_KEEP;
      if (strb.softRst)     ienReg <= '0;
      else if (strb.ienWr)  ienReg <= wrData & IEN_KEEP;
      if (strb.softRst)       txSetReg <= '0;
      else if (strb.txSetWr)  txSetReg <= wrData & TX_ACT_KEEP;
      if (strb.softRst)       rxSetReg <= '0;
      else if (strb.rxSetWr)  rxSetReg <= wrData & RX_ACT_KEEP;
      errReg   <= nextStatus(errReg,   strb.errClr,   strb.softRst, wrData, errSet);
      txEobReg <= nextStatus(txEobReg, strb.txEobClr, strb.softRst, wrData, txEobSet);
      txDeReg  <= nextStatus(txDeReg,  strb.txDeClr,  strb.softRst, wrData, txDescErrSet);
      rxEobReg <= nextStatus(rxEobReg, strb.rxEobClr, strb.softRst, wrData, rxEobSet);
      rxDeReg  <= nextStatus(rxDeReg,  strb.rxDeClr,  strb.softRst, wrData, rxDescErrSet);
    end
  end

  // Storage that no reset touches.
  always_ff @(posedge clk) begin
    if (strb.txRstWr) txRstReg <= wrData & TX_ACT_KEEP;
    if (strb.rxRstWr) rxRstReg <= wrData & RX_ACT_KEEP;
  end

  for (genvar i = 0; i < TX_CH; i++) begin : g_txPtr
    always_ff @(posedge clk) begin
      if (strb.txPtrWr && chanIdx == CHIDX_W'(i)) txPtr[i] <= wrData;
    end
    assert_txptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.txPtrWr && chanIdx == CHIDX_W'(i)) |=> $stable(txPtr[i]));
  end

  for (genvar i = 0; i < RX_CH; i++) begin : g_rxChan
    always_ff @(posedge clk) begin
      if (strb.rxPtrWr && chanIdx == CHIDX_W'(i)) rxPtr[i] <= wrData;
      if (strb.bufSzWr && chanIdx == CHIDX_W'(i)) bufSz[i] <= wrData & BUF_KEEP;
    end
    assert_bufsz_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.bufSzWr && chanIdx == CHIDX_W'(i)) |=> $stable(bufSz[i]));
  end

  always_comb begin
    rdMux = '0;
    unique case (sel)
      SEL_CFG:   rdMux = cfgReg;
      SEL_ERR:   rdMux = errReg;
      SEL_IEN:   rdMux = ienReg;
      SEL_TXSET: rdMux = txSetReg;
      SEL_TXRST: rdMux = txRstReg;
      SEL_TXEOB: rdMux = txEobReg;
      SEL_TXDE:  rdMux = txDeReg;
      SEL_RXSET: rdMux = rxSetReg;
      SEL_RXRST: rdMux = rxRstReg;
      SEL_RXEOB: rdMux = rxEobReg;
      SEL_RXDE:  rdMux = rxDeReg;
      SEL_TXPTR: for (int i = 0; i < TX_CH; i++) if (chanIdx == CHIDX_W'(i)) rdMux = txPtr[i];
      SEL_RXPTR: for (int i = 0; i < RX_CH; i++) if (chanIdx == CHIDX_W'(i)) rdMux = rxPtr[i];
      SEL_BUFSZ: for (int i = 0; i < RX_CH; i++) if (chanIdx == CHIDX_W'(i)) rdMux = bufSz[i];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      irqReg <= '0;
    end else begin
      rdData <= rdStb ? rdMux : '0;
      irqReg <= '0;
    end
  end

  assign irqOut = irqReg;

  assert_cfg_top_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[31]);
  assert_soft_reset_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (ienReg == '0 && txSetReg == '0 && rxSetReg == '0));
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errClr && errSet == '0) |=> ((errReg & $past(wrData)) == '0));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errSet != '0) |=> ((errReg & $past(errSet)) == $past(errSet)));
  assert_irq_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == '0);

endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
#(
  parameter int TX_CHANNELS = 4,
  parameter int RX_CHANNELS = 2,
  parameter int IRQ_LINES   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [9:0]           regNum,
  input  logic [31:0]          wrData,
  input  logic                 rdStb,
  input  logic                 wrStb,
  output logic [31:0]          rdData,
  output logic                 ack,
  input  logic [31:0]          errSet,
  input  logic [31:0]          txEobSet,
  input  logic [31:0]          txDescErrSet,
  input  logic [31:0]          rxEobSet,
  input  logic [31:0]          rxDescErrSet,
  output logic [IRQ_LINES-1:0] irqOut
);

  regSel_e            sel;
  logic [CHIDX_W-1:0] chanIdx;
  wrStrobes_t         strb;

  dma_ctl_decode #(.TX_CH(TX_CHANNELS), .RX_CH(RX_CHANNELS)) decode_i (
    .clk(clk), .rstN(rstN), .regNum(regNum), .rdStb(rdStb), .wrStb(wrStb),
    .wrTopBit(wrData[31]), .sel(sel), .chanIdx(chanIdx), .strb(strb), .ack(ack)
  );

  dma_ctl_store #(.TX_CH(TX_CHANNELS), .RX_CH(RX_CHANNELS), .IRQ_LINES(IRQ_LINES)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sel(sel), .chanIdx(chanIdx), .rdStb(rdStb),
    .wrData(wrData), .errSet(errSet), .txEobSet(txEobSet), .txDescErrSet(txDescErrSet),
    .rxEobSet(rxEobSet), .rxDescErrSet(rxDescErrSet), .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: tb/dma_ctl_regfile_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regNum = '0;
  logic [31:0] wrData = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0;
  logic [31:0] rdData;
  logic        ack;
  logic [31:0] errSet = '0, txEobSet = '0, txDescErrSet = '0, rxEobSet = '0, rxDescErrSet = '0;
  logic [3:0]  irqOut;

  int vecCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  dma_ctl_regfile dut_i (
    .clk(clk), .rstN(rstN), .regNum(regNum), .wrData(wrData), .rdStb(rdStb), .wrStb(wrStb),
    .rdData(rdData), .ack(ack), .errSet(errSet), .txEobSet(txEobSet),
    .txDescErrSet(txDescErrSet), .rxEobSet(rxEobSet), .rxDescErrSet(rxDescErrSet),
    .irqOut(irqOut)
  );

  // Expected state, derived from the requirements.
  logic [31:0] mCfg, mErr, mIen, mTxSet, mTxRst, mTxEob, mTxDe;
  logic [31:0] mRxSet, mRxRst, mRxEob, mRxDe;
  logic [31:0] mTxPtr [4];
  logic [31:0] mRxPtr [2];
  logic [31:0] mBuf [2];

  task automatic modelResetRegs();
    mCfg = 32'h0007C000; mErr = 0; mIen = 0; mTxSet = 0; mRxSet = 0;
    mTxEob = 0; mTxDe = 0; mRxEob = 0; mRxDe = 0;
  endtask

  function automatic logic [31:0] expRead(input logic [9:0] n);
    case (n)
      10'h180: return mCfg;   10'h181: return mErr;   10'h182: return mIen;
      10'h184: return mTxSet; 10'h185: return mTxRst; 10'h186: return mTxEob;
      10'h187: return mTxDe;  10'h190: return mRxSet; 10'h191: return mRxRst;
      10'h192: return mRxEob; 10'h193: return mRxDe;
      10'h1A0, 10'h1A1, 10'h1A2, 10'h1A3: return mTxPtr[n - 10'h1A0];
      10'h1C0, 10'h1C1: return mRxPtr[n - 10'h1C0];
      10'h1E0, 10'h1E1: return mBuf[n - 10'h1E0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input logic [9:0] n, input logic [31:0] d);
    case (n)
      10'h180: begin if (d[31]) modelResetRegs(); mCfg = d & 32'h00FFC087; end
      10'h181: mErr &= ~d;
      10'h182: mIen = d & 32'h1F;
      10'h184: mTxSet = d & 32'hF0000000;
      10'h185: mTxRst = d & 32'hF0000000;
      10'h186: mTxEob &= ~d;
      10'h187: mTxDe &= ~d;
      10'h190: mRxSet = d & 32'hC0000000;
      10'h191: mRxRst = d & 32'hC0000000;
      10'h192: mRxEob &= ~d;
      10'h193: mRxDe &= ~d;
      10'h1A0, 10'h1A1, 10'h1A2, 10'h1A3: mTxPtr[n - 10'h1A0] = d;
      10'h1C0, 10'h1C1: mRxPtr[n - 10'h1C0] = d;
      10'h1E0, 10'h1E1: mBuf[n - 10'h1E0] = d & 32'hFF;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle with optional set pulses; checks ack and read data.
  task automatic busOp(input bit rd, input bit wr, input logic [9:0] n, input logic [31:0] d,
                       input logic [31:0] sE, input logic [31:0] sTE, input logic [31:0] sTD,
                       input logic [31:0] sRE, input logic [31:0] sRD, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    exp = expRead(n);
    regNum = n; wrData = d; rdStb = rd; wrStb = wr;
    errSet = sE; txEobSet = sTE; txDescErrSet = sTD; rxEobSet = sRE; rxDescErrSet = sRD;
    if (wr) modelWrite(n, d);
    mErr |= sE; mTxEob |= sTE; mTxDe |= sTD; mRxEob |= sRE; mRxDe |= sRD;
    @(negedge clk);
    rdStb = 0; wrStb = 0;
    errSet = 0; txEobSet = 0; txDescErrSet = 0; rxEobSet = 0; rxDescErrSet = 0;
    if (rd || wr) check({tag, " R11 ack"}, {31'h0, ack}, 32'h1);
    if (rd) check(tag, rdData, exp);
  endtask

  task automatic rdReg(input logic [9:0] n, input string tag);
    busOp(1, 0, n, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wrReg(input logic [9:0] n, input logic [31:0] d);
    busOp(0, 1, n, d, 0, 0, 0, 0, 0, "R11 write");
  endtask

  function automatic logic [9:0] pickNum(input int k);
    logic [9:0] tbl [24] = '{10'h180, 10'h181, 10'h182, 10'h184, 10'h185, 10'h186, 10'h187,
                             10'h190, 10'h191, 10'h192, 10'h193, 10'h1A0, 10'h1A1, 10'h1A2,
                             10'h1A3, 10'h1C0, 10'h1C1, 10'h1E0, 10'h1E1, 10'h183, 10'h1A4,
                             10'h1C2, 10'h1E2, 10'h000};
    return tbl[k];
  endfunction

  task automatic readAll(input string tag);
    for (int k = 0; k < 24; k++) rdReg(pickNum(k), tag);
  endtask

  task automatic powerOnReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    modelResetRegs();
    check("R11 ack in reset", {31'h0, ack}, 32'h0);
    rstN = 1;
  endtask

  initial begin
    #(8 * 150000);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    modelResetRegs();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R4 reset values, R12 interrupt lines
    for (int k = 0; k < 11; k++) rdReg(pickNum(k) == 10'h185 || pickNum(k) == 10'h191 ? 10'h180 : pickNum(k), "R4 reset value");
    check("R12 irq after reset", {28'h0, irqOut}, 32'h0);

    // R8/R9 masks on plain storage
    wrReg(10'h185, 32'hFFFFFFFF); rdReg(10'h185, "R8 tx active-reset mask");
    wrReg(10'h191, 32'hFFFFFFFF); rdReg(10'h191, "R8 rx active-reset mask");
    wrReg(10'h184, 32'hFFFFFFFF); rdReg(10'h184, "R8 tx active-set mask");
    wrReg(10'h190, 32'hFFFFFFFF); rdReg(10'h190, "R8 rx active-set mask");
    wrReg(10'h182, 32'hFFFFFFFF); rdReg(10'h182, "R8 interrupt enable mask");
    for (int i = 0; i < 4; i++) begin
      wrReg(10'h1A0 + 10'(i), 32'hA5A50000 + 32'(i)); rdReg(10'h1A0 + 10'(i), "R9 tx pointer");
    end
    for (int i = 0; i < 2; i++) begin
      wrReg(10'h1C0 + 10'(i), 32'h5A5A0000 + 32'(i)); rdReg(10'h1C0 + 10'(i), "R9 rx pointer");
      wrReg(10'h1E0 + 10'(i), 32'hFFFFFF30 + 32'(i)); rdReg(10'h1E0 + 10'(i), "R9 buffer size");
    end

    // R6 write-one-to-clear on all five status registers
    busOp(0, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, "set");
    wrReg(10'h181, 32'h0000FFFF); rdReg(10'h181, "R6 error status clear");
    wrReg(10'h186, 32'hFF00FF00); rdReg(10'h186, "R6 tx eob clear");
    wrReg(10'h187, 32'h00000001); rdReg(10'h187, "R6 tx desc err clear");
    wrReg(10'h192, 32'h80000000); rdReg(10'h192, "R6 rx eob clear");
    wrReg(10'h193, 32'h12345678); rdReg(10'h193, "R6 rx desc err clear");

    // R7 set wins over a clear in the same cycle
    busOp(0, 1, 10'h181, 32'hFFFFFFFF, 32'h00000010, 0, 0, 0, 0, "R7");
    rdReg(10'h181, "R7 set beats clear");

    // R2 config mask without soft reset
    wrReg(10'h180, 32'h7FFFFFFF); rdReg(10'h180, "R2 config mask");
    rdReg(10'h182, "R2 no soft reset without bit31");

    // R3 soft reset, with a set pulse landing in the same cycle (R7)
    busOp(0, 1, 10'h180, 32'hFFFFFFFF, 0, 32'h00000004, 0, 0, 0, "R3");
    rdReg(10'h180, "R3 config after soft reset");
    rdReg(10'h182, "R3 ien cleared");
    rdReg(10'h184, "R3 tx active-set cleared");
    rdReg(10'h190, "R3 rx active-set cleared");
    rdReg(10'h181, "R3 error cleared");
    rdReg(10'h186, "R7 set survives soft reset");
    rdReg(10'h193, "R3 rx desc err cleared");
    rdReg(10'h185, "R5 tx active-reset kept");
    rdReg(10'h191, "R5 rx active-reset kept");
    rdReg(10'h1A3, "R5 tx pointer kept");
    rdReg(10'h1E1, "R5 buffer size kept");

    // R10 unmapped numbers
    for (int k = 19; k < 24; k++) begin
      wrReg(pickNum(k), 32'hFFFFFFFF);
      rdReg(pickNum(k), "R10 unmapped reads zero");
    end
    readAll("R10 map unchanged");

    // R5 power-on reset keeps storage
    powerOnReset();
    readAll("R5 after power-on reset");

    // Random traffic, R1 decode
    for (int n = 0; n < 3000; n++) begin
      logic [9:0]  num;
      logic [31:0] d, s0, s1, s2, s3, s4;
      bit isWr;
      num = pickNum($urandom_range(23));
      isWr = $urandom_range(1) == 1;
      d = $urandom;
      if (num == 10'h180 && $urandom_range(3) != 0) d[31] = 1'b0;
      s0 = ($urandom_range(7) == 0) ? $urandom & $urandom : 0;
      s1 = ($urandom_range(7) == 0) ? $urandom & $urandom : 0;
      s2 = ($urandom_range(7) == 0) ? $urandom & $urandom : 0;
      s3 = ($urandom_range(7) == 0) ? $urandom & $urandom : 0;
      s4 = ($urandom_range(7) == 0) ? $urandom & $urandom : 0;
      busOp(!isWr, isWr, num, d, s0, s1, s2, s3, s4, "R1 random");
      check("R12 irq low", {28'h0, irqOut}, 32'h0);
    end
    readAll("R1 final sweep");

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule